// File: doc/BRIEF.md
# Directed Rounding and Overflow Unit

This block takes an unsigned mantissa magnitude with a separate sign, where the two lowest bits of the input are the guard and round bits, and a separate sticky flag. It drops those two low bits and decides from the rounding mode whether to add one to the kept part. The add carries across every word of the mantissa. The block returns the rounded magnitude, a flag that shows the value was rounded up, an inexact flag and the carry out of the top bit. When the carry out is set, the value has reached 2.0, and the block returns it without renormalising it. Adjusting the exponent is left to the caller.

A second, independent answer on the same mode input says whether an overflowing result of a given sign should saturate to infinity or to the largest finite magnitude.

The datapath is purely combinational. A parameter chooses between two forms of the output:
- a registered output stage that captures on a valid strobe and raises a valid flag one cycle later;
- a direct pass-through, in which the valid flag follows the input strobe.

Top module: `dround_unit`

## Requirements
- R1: The kept mantissa is input bits [KEEP_W+1:2]. Input bit 1 is the guard bit and input bit 0 is the round bit. The sticky flag is a separate input and is never shifted into the kept part.
- R2: When guard, round and sticky are all 0, the output mantissa equals the kept mantissa, and rounded_up, inexact and carry_out are all 0.
- R3: inexact is 1 exactly when guard, round or sticky is 1, in every mode.
- R4: In nearest mode (rnd_mode = 2'b00), the unit rounds up only when guard is 1 and at least one of these is 1: the round bit, sticky, or kept bit 0. An exact tie (guard 1, round 0, sticky 0) therefore rounds to an even kept value.
- R5: Toward-zero mode (2'b01) never rounds up. Toward-minus-infinity mode (2'b10) rounds up only an inexact value with sign 1. Toward-plus-infinity mode (2'b11) rounds up only an inexact value with sign 0.
- R6: A round-up adds one with a carry rippled across all words. An all-ones kept mantissa that rounds up gives an all-zero mantissa with carry_out 1. Without a round-up, carry_out is 0.
- R7: ovf_to_inf is 1 in nearest mode and 0 in toward-zero mode. In plus-infinity mode it equals NOT ovf_sign, and in minus-infinity mode it equals ovf_sign.
- R8: With REG_OUT=1, all results and out_valid appear on the first clock edge after the edge that samples in_valid=1. While in_valid is 0, out_valid falls and the result outputs hold their previous values.
- R9: With REG_OUT=0, the results follow the inputs combinationally and out_valid equals in_valid.
- R10: After reset with REG_OUT=1, out_valid and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| val_sign | input | 1 | Sign of the value being rounded (1 = negative) |
| mant_in | input | KEEP_W+2 | Kept mantissa followed by the guard bit and the round bit |
| sticky_in | input | 1 | OR of all bits below the round bit |
| ovf_sign | input | 1 | Sign used for the overflow query |
| out_valid | output | 1 | Result valid |
| mant_out | output | KEEP_W | Rounded mantissa (low KEEP_W bits of the sum) |
| rounded_up | output | 1 | The value was incremented |
| inexact | output | 1 | Guard, round or sticky was nonzero |
| carry_out | output | 1 | The increment overflowed the kept width (the value reached 2.0) |
| ovf_to_inf | output | 1 | 1: the overflow goes to infinity; 0: it goes to the largest finite value |

## Verification
The bench builds two instances:

| Instance | KEEP_W | WORD_W | REG_OUT |
|---|---|---|---|
| Wide | 64 | 16 | 1 |
| Narrow | 8 | 4 | 0 |

The wide instance exercises the registered stage and a carry that crosses three word boundaries of an all-ones mantissa, and covers exact ties on both even and odd kept values. The narrow instance makes an exhaustive sweep practical: every mantissa, sticky value, sign and mode combination is compared against a model built from the requirements. That sweep also covers a carry through a partial two-word chain.

// File: rtl/dround_pkg.sv
package dround_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_TOZERO  = 2'b01,
        RM_DOWN    = 2'b10,
        RM_UP      = 2'b11
    } rmode_e;

endpackage

// File: rtl/dround_decide.sv
// Round-up decision from the guard, round and sticky bits and the mode.
module dround_decide
    import dround_pkg::*;
(
    input  rmode_e mode,
    input  logic   sign,
    input  logic   guard,
    input  logic   rbit,
    input  logic   sticky,
    input  logic   lsb,
    output logic   inc,
    output logic   inexact
);

    logic lost;

    always_comb begin
        lost    = guard | rbit | sticky;
        inexact = lost;
        inc     = 1'b0;
        if (lost) begin
            unique case (mode)
                RM_NEAREST: inc = guard & (rbit | sticky | lsb);
                RM_TOZERO:  inc = 1'b0;
                RM_DOWN:    inc = sign;
                RM_UP:      inc = ~sign;
            endcase
        end
    end

endmodule

// File: rtl/dround_ovf.sv
// Overflow target: infinity (1) or largest finite magnitude (0).
module dround_ovf
    import dround_pkg::*;
(
    input  rmode_e mode,
    input  logic   sign,
    output logic   to_inf
);

    always_comb begin
        unique case (mode)
            RM_NEAREST: to_inf = 1'b1;
            RM_TOZERO:  to_inf = 1'b0;
            RM_DOWN:    to_inf = sign;
            RM_UP:      to_inf = ~sign;
        endcase
    end

endmodule

// File: rtl/dround_incr.sv
// Word-sliced incrementer with a rippled carry between the slices.
module dround_incr #(
    parameter int W      = 64,
    parameter int WORD_W = 16
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] y,
    output logic         cout
);

    localparam int NW = (W + WORD_W - 1) / WORD_W;

    logic [NW:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam int LO = i * WORD_W;
        localparam int HI = ((i + 1) * WORD_W > W) ? W - 1 : (i + 1) * WORD_W - 1;
        localparam int WW = HI - LO + 1;

        logic [WW:0] s;

        assign s         = {1'b0, a[HI:LO]} + {{WW{1'b0}}, c[i]};
        assign y[HI:LO]  = s[WW-1:0];
        assign c[i+1]    = s[WW];
    end

    assign cout = c[NW];

endmodule

// File: rtl/dround_unit.sv
module dround_unit
    import dround_pkg::*;
#(
    parameter int KEEP_W  = 64,
    parameter int WORD_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        rnd_mode,
    input  logic              val_sign,
    input  logic [KEEP_W+1:0] mant_in,
    input  logic              sticky_in,
    input  logic              ovf_sign,
    output logic              out_valid,
    output logic [KEEP_W-1:0] mant_out,
    output logic              rounded_up,
    output logic              inexact,
    output logic              carry_out,
    output logic              ovf_to_inf
);

    localparam int IN_W = KEEP_W + 2;

    rmode_e            mode;
    logic [KEEP_W-1:0] kept;
    logic              g_bit;
    logic              r_bit;
    logic              inc_c;
    logic              inexact_c;
    logic [KEEP_W-1:0] sum_c;
    logic              carry_c;
    logic              to_inf_c;

    assign mode  = rmode_e'(rnd_mode);
    assign kept  = mant_in[IN_W-1:2];
    assign g_bit = mant_in[1];
    assign r_bit = mant_in[0];

    dround_decide u_decide (
        .mode    (mode),
        .sign    (val_sign),
        .guard   (g_bit),
        .rbit    (r_bit),
        .sticky  (sticky_in),
        .lsb     (kept[0]),
        .inc     (inc_c),
        .inexact (inexact_c)
    );

    dround_incr #(.W(KEEP_W), .WORD_W(WORD_W)) u_incr (
        .a    (kept),
        .cin  (inc_c),
        .y    (sum_c),
        .cout (carry_c)
    );

    dround_ovf u_ovf (
        .mode   (mode),
        .sign   (ovf_sign),
        .to_inf (to_inf_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid  <= 1'b0;
                mant_out   <= '0;
                rounded_up <= 1'b0;
                inexact    <= 1'b0;
                carry_out  <= 1'b0;
                ovf_to_inf <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    mant_out   <= sum_c;
                    rounded_up <= inc_c;
                    inexact    <= inexact_c;
                    carry_out  <= carry_c;
                    ovf_to_inf <= to_inf_c;
                end
            end
        end

        p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> out_valid == $past(in_valid));
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(mant_out) && $stable(inexact));
    end else begin : g_comb
        assign out_valid  = in_valid;
        assign mant_out   = sum_c;
        assign rounded_up = inc_c;
        assign inexact    = inexact_c;
        assign carry_out  = carry_c;
        assign ovf_to_inf = to_inf_c;
    end

    p_exact_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_bit && !r_bit && !sticky_in) |-> (!inc_c && sum_c == kept && !inexact_c));
    p_near_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_NEAREST && !g_bit) |-> !inc_c);
    p_tozero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_TOZERO) |-> !inc_c);
    p_carry_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_c |-> (inc_c && sum_c == '0 && (&kept)));
    p_ovf_tozero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_TOZERO) |-> !to_inf_c);

endmodule

// File: tb/dround_unit_bench.sv
module dround_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int KW = 64;
    localparam int NK = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    rnd_mode = 2'b00;
    logic          val_sign = 1'b0;
    logic [KW+1:0] mant_in = '0;
    logic          sticky_in = 1'b0;
    logic          ovf_sign = 1'b0;
    logic          out_valid;
    logic [KW-1:0] mant_out;
    logic          rounded_up, inexact, carry_out, ovf_to_inf;

    logic [1:0]    n_mode = 2'b00;
    logic          n_sign = 1'b0;
    logic [NK+1:0] n_mant = '0;
    logic          n_sticky = 1'b0;
    logic          n_valid = 1'b0;
    logic          n_ovf_sign = 1'b0;
    logic          n_out_valid;
    logic [NK-1:0] n_mant_out;
    logic          n_up, n_inx, n_cy, n_inf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dround_unit #(.KEEP_W(KW), .WORD_W(16), .REG_OUT(1'b1)) u_dround_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rnd_mode(rnd_mode),
        .val_sign(val_sign), .mant_in(mant_in), .sticky_in(sticky_in),
        .ovf_sign(ovf_sign), .out_valid(out_valid), .mant_out(mant_out),
        .rounded_up(rounded_up), .inexact(inexact), .carry_out(carry_out),
        .ovf_to_inf(ovf_to_inf)
    );

    dround_unit #(.KEEP_W(NK), .WORD_W(4), .REG_OUT(1'b0)) u_dround_unit_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .rnd_mode(n_mode),
        .val_sign(n_sign), .mant_in(n_mant), .sticky_in(n_sticky),
        .ovf_sign(n_ovf_sign), .out_valid(n_out_valid), .mant_out(n_mant_out),
        .rounded_up(n_up), .inexact(n_inx), .carry_out(n_cy),
        .ovf_to_inf(n_inf)
    );

    function automatic logic ref_up(input logic [1:0] m, input logic sg,
                                    input logic g, input logic r,
                                    input logic s, input logic lsb);
        if (!(g | r | s)) return 1'b0;
        case (m)
            2'b00:   return g & (r | s | lsb);
            2'b01:   return 1'b0;
            2'b10:   return sg;
            default: return ~sg;
        endcase
    endfunction

    function automatic logic ref_inf(input logic [1:0] m, input logic sg);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return sg;
            default: return ~sg;
        endcase
    endfunction

    task automatic check(input string req, input logic [KW-1:0] got,
                         input logic [KW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive one operand into the wide instance and wait until its result is visible.
    task automatic apply(input logic [1:0] m, input logic sg, input logic [KW+1:0] v,
                         input logic s, input logic osg);
        @(negedge clk);
        rnd_mode = m; val_sign = sg; mant_in = v; sticky_in = s; ovf_sign = osg;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Compare every wide output with the model for the operand just applied.
    task automatic check_wide(input string req, input logic [1:0] m, input logic sg,
                              input logic [KW+1:0] v, input logic s, input logic osg);
        logic          up;
        logic [KW:0]   sum;
        up  = ref_up(m, sg, v[1], v[0], s, v[2]);
        sum = {1'b0, v[KW+1:2]} + {{KW{1'b0}}, up};
        check({req, " mant"}, mant_out, sum[KW-1:0]);
        check({req, " up"}, {63'd0, rounded_up}, {63'd0, up});
        check({req, " inexact"}, {63'd0, inexact}, {63'd0, (v[1] | v[0] | s)});
        check({req, " carry"}, {63'd0, carry_out}, {63'd0, sum[KW]});
        check({req, " ovf"}, {63'd0, ovf_to_inf}, {63'd0, ref_inf(m, osg)});
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset();
        check("R10 valid", {63'd0, out_valid}, 64'd0);
        check("R10 mant", mant_out, 64'd0);
        check("R10 flags", {60'd0, rounded_up, inexact, carry_out, ovf_to_inf}, 64'd0);
    endtask

    task automatic t_exact();
        // R2: nothing below the kept bits, so the kept value passes through unchanged.
        for (int m = 0; m < 4; m++) begin
            logic [KW+1:0] v;
            v = {64'h0123_4567_89AB_CDEF, 2'b00};
            apply(2'(m), 1'b1, v, 1'b0, 1'b0);
            check_wide("R2 exact", 2'(m), 1'b1, v, 1'b0, 1'b0);
        end
    endtask

    task automatic t_sticky_only();
        // R1, R3: sticky alone marks the result inexact and is not shifted into the mantissa.
        logic [KW+1:0] v;
        v = {64'h0000_0000_0000_0010, 2'b00};
        apply(2'b01, 1'b0, v, 1'b1, 1'b0);
        check_wide("R1 R3 sticky", 2'b01, 1'b0, v, 1'b1, 1'b0);
        check("R1 mant kept", mant_out, 64'h10);
    endtask

    task automatic t_ties();
        // R4: ties on even and odd kept values, and a case above the halfway point.
        logic [KW+1:0] v;
        v = {64'h0000_0000_0000_0004, 2'b10};
        apply(2'b00, 1'b0, v, 1'b0, 1'b1);
        check_wide("R4 tie even", 2'b00, 1'b0, v, 1'b0, 1'b1);
        check("R4 tie even stays", mant_out, 64'h4);
        v = {64'h0000_0000_0000_0005, 2'b10};
        apply(2'b00, 1'b0, v, 1'b0, 1'b1);
        check_wide("R4 tie odd", 2'b00, 1'b0, v, 1'b0, 1'b1);
        check("R4 tie odd up", mant_out, 64'h6);
        v = {64'h0000_0000_0000_0004, 2'b10};
        apply(2'b00, 1'b0, v, 1'b1, 1'b0);
        check_wide("R4 above half", 2'b00, 1'b0, v, 1'b1, 1'b0);
        v = {64'h0000_0000_0000_0005, 2'b01};
        apply(2'b00, 1'b0, v, 1'b1, 1'b0);
        check_wide("R4 below half", 2'b00, 1'b0, v, 1'b1, 1'b0);
    endtask

    task automatic t_directed();
        // R5, R8: each directed mode under both signs; rnd_mode 10 is minus-infinity, 11 is plus-infinity.
        for (int m = 1; m < 4; m++) begin
            for (int sg = 0; sg < 2; sg++) begin
                logic [KW+1:0] v;
                v = {64'h0000_0000_0000_0100, 2'b01};
                apply(2'(m), 1'(sg), v, 1'b0, 1'(sg));
                check_wide("R5 R8 directed", 2'(m), 1'(sg), v, 1'b0, 1'(sg));
            end
        end
    endtask

    task automatic t_carry();
        // R6: an all-ones mantissa wraps to zero with carry out; partial ones ripple across words.
        logic [KW+1:0] v;
        v = {{KW{1'b1}}, 2'b11};
        apply(2'b00, 1'b0, v, 1'b0, 1'b0);
        check_wide("R6 all ones", 2'b00, 1'b0, v, 1'b0, 1'b0);
        check("R6 wrap mant", mant_out, 64'd0);
        check("R6 wrap carry", {63'd0, carry_out}, 64'd1);
        v = {64'h0000_FFFF_FFFF_FFFF, 2'b01};
        apply(2'b11, 1'b0, v, 1'b0, 1'b0);
        check_wide("R6 ripple", 2'b11, 1'b0, v, 1'b0, 1'b0);
        check("R6 ripple value", mant_out, 64'h0001_0000_0000_0000);
    endtask

    task automatic t_overflow();
        // R7: overflow target in all mode and sign pairs.
        for (int m = 0; m < 4; m++) begin
            for (int sg = 0; sg < 2; sg++) begin
                apply(2'(m), 1'b0, '0, 1'b0, 1'(sg));
                check("R7 ovf", {63'd0, ovf_to_inf}, {63'd0, ref_inf(2'(m), 1'(sg))});
            end
        end
    endtask

    task automatic t_hold();
        // R8: while in_valid is low, new inputs are ignored and the outputs hold.
        logic [KW+1:0] v;
        v = {64'hAAAA_0000_5555_0003, 2'b11};
        apply(2'b00, 1'b0, v, 1'b0, 1'b0);
        @(negedge clk);
        rnd_mode = 2'b01; mant_in = '0; sticky_in = 1'b0;
        @(negedge clk);
        check("R8 valid low", {63'd0, out_valid}, 64'd0);
        check("R8 hold mant", mant_out, 64'hAAAA_0000_5555_0004);
        check("R8 hold inexact", {63'd0, inexact}, 64'd1);
    endtask

    task automatic t_narrow_sweep();
        // R9 plus R1 to R7: exhaustive sweep of the combinational instance.
        int bad;
        bad = 0;
        n_valid = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < (1 << (NK + 2)); v++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int sg = 0; sg < 2; sg++) begin
                        logic          up;
                        logic [NK:0]   sum;
                        logic [NK+1:0] vv;
                        vv = (NK+2)'(v);
                        n_mode = 2'(m); n_mant = vv; n_sticky = 1'(s);
                        n_sign = 1'(sg); n_ovf_sign = 1'(sg);
                        #1;
                        up  = ref_up(2'(m), 1'(sg), vv[1], vv[0], 1'(s), vv[2]);
                        sum = {1'b0, vv[NK+1:2]} + {{NK{1'b0}}, up};
                        checks++;
                        if (n_mant_out !== sum[NK-1:0] || n_up !== up || n_cy !== sum[NK] ||
                            n_inx !== (vv[1] | vv[0] | 1'(s)) ||
                            n_inf !== ref_inf(2'(m), 1'(sg)) || n_out_valid !== 1'b1) begin
                            fails++;
                            bad++;
                            if (bad < 5)
                                $display("FAIL R9 narrow m=%0d v=%h s=%0d sg=%0d actual=%h/%b%b%b%b expected=%h/%b%b%b%b",
                                         m, vv, s, sg, n_mant_out, n_up, n_cy, n_inx, n_inf,
                                         sum[NK-1:0], up, sum[NK], (vv[1] | vv[0] | 1'(s)),
                                         ref_inf(2'(m), 1'(sg)));
                        end
                    end
                end
            end
        end
        n_valid = 1'b0;
        #1;
        check("R9 valid follows", {63'd0, n_out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_exact();
        t_sticky_only();
        t_ties();
        t_directed();
        t_carry();
        t_overflow();
        t_hold();
        t_narrow_sweep();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule